// File: doc/BRIEF.md
# Delayed Branch Next-PC Unit

This block sequences the program counter of a 64-bit RISC core whose control transfers take effect only after one architectural delay slot. It owns the fetch address register. On each cycle in which `step` is high, the instruction at `fetch_pc` is considered executed, and its decoded control class, offset fields and two register operands are presented on the inputs. The unit decides whether a transfer happens and where it goes. It always lets the next sequential instruction, the delay slot, run first, and it moves to the chosen target on the step after that.

Branch-likely forms run the delay slot only when taken. When such a branch falls through, the unit raises `annul` while the slot instruction is presented, so that the core squashes it. The unit also ignores that instruction's decode. Link-forming jumps report a return address and a write strobe for register 31. The `in_slot` flag marks the cycle in which a delay-slot instruction is presented, so that exception logic can record it. The unit ignores any control class presented while `in_slot` is high, so a transfer placed in a delay slot has no redirect effect and no link effect.

Top module: `dslot_npc`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_pc` becomes RESET_PC (default 0x1000), and `in_slot`, `annul` and `link_we` are 0 afterwards.
- R2: A step with `ctl_kind` = 0 (no transfer), outside a delay slot, advances `fetch_pc` by 4. With `step` low, `fetch_pc`, `in_slot` and `annul` hold their values.
- R3: `ctl_kind` = 1 is a conditional branch. `cmp_sel` selects the test: 0 opa==opb, 1 opa!=opb, 2 opa>0, 3 opa>=0, 4 opa<=0, 5 opa<0 (zero forms signed, 64-bit), 6 and 7 never taken. When taken, the step after the delay slot fetches PC+4 plus the sign-extended `br_ofs` shifted left by 2.
- R4: A not-taken conditional branch at PC presents the slot at PC+4 with `annul` 0, then continues at PC+8.
- R5: After a step on any control class 1..6, the next presented instruction is the delay slot at PC+4 with `in_slot` 1. The step on the slot instruction clears `in_slot`.
- R6: `ctl_kind` = 2 is the branch-likely form, using the same tests as R3. If taken, the slot runs with `annul` 0 and then the target is fetched. If not taken, `annul` is 1 while the slot is presented, and execution continues at PC+8.
- R7: `ctl_kind` = 3 (jump) targets bits [63:28] of PC+4 joined with `jmp_idx` shifted left by 2.
- R8: `ctl_kind` = 4 (jump register) targets the full 64-bit `opa`.
- R9: `ctl_kind` = 5 (jump-and-link, target as R7) and 6 (jump-and-link-register, target as R8) drive `link_we` = 1 and `link_val` = PC+8 during their step. All other classes drive `link_we` = 0.
- R10: While `in_slot` is 1, including an annulled slot, the control class on `ctl_kind` is ignored: there is no link write and no redirect, and the following fetch is slot address + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | The instruction at fetch_pc executes this cycle |
| ctl_kind | input | 3 | Control class: 0 none, 1 branch, 2 branch-likely, 3 jump, 4 jump register, 5 jump-and-link, 6 jump-and-link register |
| cmp_sel | input | 3 | Branch test selector (R3) |
| br_ofs | input | 16 | Branch word offset |
| jmp_idx | input | 26 | Jump word index |
| opa | input | 64 | First register operand |
| opb | input | 64 | Second register operand |
| fetch_pc | output | 64 | Address of the instruction presented now |
| link_we | output | 1 | Write link_val to register 31 |
| link_val | output | 64 | Return address, PC+8 |
| annul | output | 1 | Squash the presented delay-slot instruction |
| in_slot | output | 1 | Presented instruction sits in a delay slot |

## Verification
The properties assume that `ctl_kind` carries only the encodings 0 to 7 defined above. Code 7 is treated as no transfer, so the fall-through and slot properties state the transfer classes as 1 to 6. They also take the operands, offset and class inputs as meaningful only in cycles where `step` is high. The bench holds `ctl_kind` at 0 whenever `step` is low, and it drives inputs on the falling edge. It places control classes in delay slots only to show that they are ignored. It reaches the upper address region through a jump register before it exercises the region-preserving jump.

// File: rtl/npc_pkg.sv
package npc_pkg;

    parameter int unsigned NPC_XLEN = 64;

    typedef enum logic [2:0] {
        CK_NONE = 3'd0,
        CK_BR   = 3'd1,
        CK_BRL  = 3'd2,
        CK_J    = 3'd3,
        CK_JR   = 3'd4,
        CK_JAL  = 3'd5,
        CK_JALR = 3'd6,
        CK_RSV  = 3'd7
    } ctl_kind_e;

    typedef enum logic [2:0] {
        CC_EQ  = 3'd0,
        CC_NE  = 3'd1,
        CC_GTZ = 3'd2,
        CC_GEZ = 3'd3,
        CC_LEZ = 3'd4,
        CC_LTZ = 3'd5,
        CC_NV6 = 3'd6,
        CC_NV7 = 3'd7
    } cmp_sel_e;

    typedef struct packed {
        logic is_ctl;
        logic taken;
        logic likely;
        logic link;
    } ctl_dec_t;

    function automatic ctl_dec_t decode_ctl(input ctl_kind_e k, input logic cond_ok);
        ctl_dec_t d;
        d = '0;
        unique case (k)
            CK_BR:   begin d.is_ctl = 1'b1; d.taken = cond_ok; end
            CK_BRL:  begin d.is_ctl = 1'b1; d.taken = cond_ok; d.likely = 1'b1; end
            CK_J,
            CK_JR:   begin d.is_ctl = 1'b1; d.taken = 1'b1; end
            CK_JAL,
            CK_JALR: begin d.is_ctl = 1'b1; d.taken = 1'b1; d.link = 1'b1; end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int unsigned XLEN = NPC_XLEN
) (
    input  cmp_sel_e          sel,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    output logic              cond_ok
);
    logic a_neg;
    logic a_zero;

    assign a_neg  = opa[XLEN-1];
    assign a_zero = (opa == '0);

    always_comb begin
        unique case (sel)
            CC_EQ:   cond_ok = (opa == opb);
            CC_NE:   cond_ok = (opa != opb);
            CC_GTZ:  cond_ok = !a_neg && !a_zero;
            CC_GEZ:  cond_ok = !a_neg;
            CC_LEZ:  cond_ok = a_neg || a_zero;
            CC_LTZ:  cond_ok = a_neg;
            default: cond_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int unsigned XLEN       = NPC_XLEN,
    parameter int unsigned OFS_W      = 16,
    parameter int unsigned JIDX_W     = 26,
    parameter int unsigned INSN_BYTES = 4
) (
    input  ctl_kind_e         kind,
    input  logic [XLEN-1:0]   pc,
    input  logic [OFS_W-1:0]  br_ofs,
    input  logic [JIDX_W-1:0] jmp_idx,
    input  logic [XLEN-1:0]   opa,
    output logic [XLEN-1:0]   seq_pc,
    output logic [XLEN-1:0]   link_pc,
    output logic [XLEN-1:0]   target
);
    localparam int unsigned SH    = $clog2(INSN_BYTES);
    localparam int unsigned JSPAN = JIDX_W + SH;

    logic [XLEN-1:0] ofs_bytes;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] region_tgt;

    assign seq_pc  = pc + XLEN'(INSN_BYTES);
    assign link_pc = pc + XLEN'(2 * INSN_BYTES);

    generate
        if (SH == 0) begin : g_byte_ofs
            assign ofs_bytes  = {{(XLEN-OFS_W){br_ofs[OFS_W-1]}}, br_ofs};
            assign region_tgt = {seq_pc[XLEN-1:JSPAN], jmp_idx};
        end else begin : g_word_ofs
            assign ofs_bytes  = {{(XLEN-OFS_W-SH){br_ofs[OFS_W-1]}}, br_ofs, {SH{1'b0}}};
            assign region_tgt = {seq_pc[XLEN-1:JSPAN], jmp_idx, {SH{1'b0}}};
        end
    endgenerate

    assign br_tgt = seq_pc + ofs_bytes;

    always_comb begin
        unique case (kind)
            CK_BR, CK_BRL:   target = br_tgt;
            CK_J, CK_JAL:    target = region_tgt;
            CK_JR, CK_JALR:  target = opa;
            default:         target = seq_pc;
        endcase
    end
endmodule

// File: rtl/npc_seq.sv
module npc_seq
    import npc_pkg::*;
#(
    parameter int unsigned     XLEN     = NPC_XLEN,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  ctl_dec_t          dec,
    input  logic [XLEN-1:0]   target,
    input  logic [XLEN-1:0]   seq_pc,
    output logic [XLEN-1:0]   pc_q,
    output logic              slot_q,
    output logic              annul_q
);
    logic            pend_q;
    logic [XLEN-1:0] pend_tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= RESET_PC;
            slot_q     <= 1'b0;
            annul_q    <= 1'b0;
            pend_q     <= 1'b0;
            pend_tgt_q <= '0;
        end else if (step) begin
            pc_q <= (slot_q && pend_q) ? pend_tgt_q : seq_pc;
            if (dec.is_ctl) begin
                slot_q     <= 1'b1;
                pend_q     <= dec.taken;
                pend_tgt_q <= target;
                annul_q    <= dec.likely && !dec.taken;
            end else begin
                slot_q  <= 1'b0;
                pend_q  <= 1'b0;
                annul_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dslot_npc.sv
module dslot_npc
    import npc_pkg::*;
#(
    parameter int unsigned         XLEN       = NPC_XLEN,
    parameter int unsigned         OFS_W      = 16,
    parameter int unsigned         JIDX_W     = 26,
    parameter int unsigned         INSN_BYTES = 4,
    parameter logic [XLEN-1:0]     RESET_PC   = XLEN'(64'h1000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [2:0]        ctl_kind,
    input  logic [2:0]        cmp_sel,
    input  logic [OFS_W-1:0]  br_ofs,
    input  logic [JIDX_W-1:0] jmp_idx,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    output logic [XLEN-1:0]   fetch_pc,
    output logic              link_we,
    output logic [XLEN-1:0]   link_val,
    output logic              annul,
    output logic              in_slot
);
    ctl_kind_e       kind_eff;
    logic            cond_ok;
    ctl_dec_t        dec;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] link_pc;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] pc_q;
    logic            slot_q;
    logic            annul_q;

    // a transfer presented in a delay slot is dropped (R10)
    assign kind_eff = slot_q ? CK_NONE : ctl_kind_e'(ctl_kind);

    npc_cond #(.XLEN(XLEN)) u_cond (
        .sel     (cmp_sel_e'(cmp_sel)),
        .opa     (opa),
        .opb     (opb),
        .cond_ok (cond_ok)
    );

    assign dec = decode_ctl(kind_eff, cond_ok);

    npc_target #(
        .XLEN(XLEN), .OFS_W(OFS_W), .JIDX_W(JIDX_W), .INSN_BYTES(INSN_BYTES)
    ) u_tgt (
        .kind    (kind_eff),
        .pc      (pc_q),
        .br_ofs  (br_ofs),
        .jmp_idx (jmp_idx),
        .opa     (opa),
        .seq_pc  (seq_pc),
        .link_pc (link_pc),
        .target  (target)
    );

    npc_seq #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .dec     (dec),
        .target  (target),
        .seq_pc  (seq_pc),
        .pc_q    (pc_q),
        .slot_q  (slot_q),
        .annul_q (annul_q)
    );

    assign fetch_pc = pc_q;
    assign link_we  = step && dec.link;
    assign link_val = link_pc;
    assign annul    = annul_q;
    assign in_slot  = slot_q;
endmodule

// File: rtl/dslot_npc_chk.sv
module dslot_npc_chk #(
    parameter int unsigned     XLEN     = 64,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input logic            clk,
    input logic            rst,
    input logic            step,
    input logic [2:0]      ctl_kind,
    input logic [XLEN-1:0] fetch_pc,
    input logic            link_we,
    input logic [XLEN-1:0] link_val,
    input logic            annul,
    input logic            in_slot
);
    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (fetch_pc == RESET_PC && !in_slot && !annul)); // R1
    AST_FALLTHRU_ADV: assert property (@(posedge clk) disable iff (rst) (step && !in_slot && ctl_kind == 3'd0) |=> fetch_pc == $past(fetch_pc) + XLEN'(4)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !step |=> ($stable(fetch_pc) && $stable(in_slot) && $stable(annul))); // R2
    AST_SLOT_FOLLOWS: assert property (@(posedge clk) disable iff (rst) (step && !in_slot && ctl_kind != 3'd0 && ctl_kind != 3'd7) |=> (in_slot && fetch_pc == $past(fetch_pc) + XLEN'(4))); // R5
    AST_SLOT_ONCE: assert property (@(posedge clk) disable iff (rst) (step && in_slot) |=> !in_slot); // R5
    AST_ANNUL_ONLY_SLOT: assert property (@(posedge clk) disable iff (rst) annul |-> in_slot); // R6
    AST_ANNUL_SKIPS: assert property (@(posedge clk) disable iff (rst) (step && annul) |=> fetch_pc == $past(fetch_pc) + XLEN'(4)); // R6
    AST_LINK_ADDR: assert property (@(posedge clk) disable iff (rst) link_we |-> (step && link_val == fetch_pc + XLEN'(8))); // R9
    AST_SLOT_NO_LINK: assert property (@(posedge clk) disable iff (rst) in_slot |-> !link_we); // R10
endmodule

bind dslot_npc dslot_npc_chk #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_chk (.*);

// File: tb/dslot_npc_test.sv
module dslot_npc_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        step;
    logic [2:0]  ctl_kind;
    logic [2:0]  cmp_sel;
    logic [15:0] br_ofs;
    logic [25:0] jmp_idx;
    logic [63:0] opa;
    logic [63:0] opb;
    logic [63:0] fetch_pc;
    logic        link_we;
    logic [63:0] link_val;
    logic        annul;
    logic        in_slot;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [63:0] RST_PC = 64'h1000;

    always #2 clk = ~clk;

    dslot_npc uut (
        .clk(clk), .rst(rst), .step(step), .ctl_kind(ctl_kind), .cmp_sel(cmp_sel),
        .br_ofs(br_ofs), .jmp_idx(jmp_idx), .opa(opa), .opb(opb),
        .fetch_pc(fetch_pc), .link_we(link_we), .link_val(link_val),
        .annul(annul), .in_slot(in_slot)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] br_target(input logic [63:0] p, input logic [15:0] ofs);
        return p + 64'd4 + {{46{ofs[15]}}, ofs, 2'b00};
    endfunction

    task automatic idle_inputs();
        step = 1'b0; ctl_kind = 3'd0; cmp_sel = 3'd0;
        br_ofs = '0; jmp_idx = '0; opa = '0; opb = '0;
    endtask

    // one control instruction at the current PC, then its delay slot
    task automatic run_ctl(input logic [2:0] k, input logic [2:0] cs, input logic [15:0] ofs,
                           input logic [25:0] ji, input logic [63:0] a, input logic [63:0] b,
                           input logic exp_taken, input logic [63:0] exp_tgt,
                           input logic exp_annul, input logic [2:0] slot_k, input string tag);
        logic [63:0] p;
        logic        exp_link;
        p = fetch_pc;
        exp_link = (k == 3'd5) || (k == 3'd6);
        step = 1'b1; ctl_kind = k; cmp_sel = cs; br_ofs = ofs; jmp_idx = ji; opa = a; opb = b;
        #1;
        chk({63'd0, link_we}, {63'd0, exp_link}, exp_link ? "R9" : tag, "link_we on transfer");
        if (exp_link) chk(link_val, p + 64'd8, "R9", "link_val");
        @(negedge clk);
        chk(fetch_pc, p + 64'd4, "R5", "slot address");
        chk({63'd0, in_slot}, 64'd1, "R5", "in_slot at slot");
        chk({63'd0, annul}, {63'd0, exp_annul}, exp_annul ? "R6" : tag, "annul at slot");
        ctl_kind = slot_k; cmp_sel = 3'd0; opa = 64'h0; opb = 64'h0; br_ofs = 16'h0040; jmp_idx = 26'h0000123;
        #1;
        chk({63'd0, link_we}, 64'd0, "R10", "no link in slot");
        @(negedge clk);
        chk(fetch_pc, exp_taken ? exp_tgt : p + 64'd8, tag, "address after slot");
        chk({63'd0, in_slot}, 64'd0, "R5", "in_slot cleared");
        idle_inputs();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle_inputs();
        repeat (2) @(negedge clk);
        chk(fetch_pc, RST_PC, "R1", "reset pc");
        chk({63'd0, in_slot}, 64'd0, "R1", "reset in_slot");
        chk({63'd0, annul}, 64'd0, "R1", "reset annul");
        chk({63'd0, link_we}, 64'd0, "R1", "reset link_we");
        rst = 1'b0;
        @(negedge clk);
        chk(fetch_pc, RST_PC, "R1", "pc after reset release");
    endtask

    task automatic t_sequential();
        logic [63:0] p;
        p = fetch_pc;
        step = 1'b1;
        repeat (3) @(negedge clk);
        chk(fetch_pc, p + 64'd12, "R2", "three sequential steps");
        step = 1'b0;
        repeat (3) @(negedge clk);
        chk(fetch_pc, p + 64'd12, "R2", "hold while step low");
        chk({63'd0, in_slot}, 64'd0, "R2", "in_slot stays low");
    endtask

    task automatic t_branches();
        logic [63:0] p;
        p = fetch_pc; run_ctl(3'd1, 3'd0, 16'h0005, '0, 64'h55, 64'h55, 1'b1, br_target(p, 16'h0005), 1'b0, 3'd0, "R3");
        p = fetch_pc; run_ctl(3'd1, 3'd0, 16'h0005, '0, 64'h55, 64'h56, 1'b0, '0, 1'b0, 3'd0, "R4");
        p = fetch_pc; run_ctl(3'd1, 3'd1, 16'hFFFE, '0, 64'h1, 64'h2, 1'b1, br_target(p, 16'hFFFE), 1'b0, 3'd0, "R3");
        p = fetch_pc; run_ctl(3'd1, 3'd2, 16'h0010, '0, 64'hFFFF_FFFF_FFFF_FFFF, '0, 1'b0, '0, 1'b0, 3'd0, "R3");
        p = fetch_pc; run_ctl(3'd1, 3'd5, 16'h0010, '0, 64'hFFFF_FFFF_FFFF_FFFF, '0, 1'b1, br_target(p, 16'h0010), 1'b0, 3'd0, "R3");
        p = fetch_pc; run_ctl(3'd1, 3'd3, 16'h0003, '0, 64'h0, '0, 1'b1, br_target(p, 16'h0003), 1'b0, 3'd0, "R3");
        p = fetch_pc; run_ctl(3'd1, 3'd4, 16'h0003, '0, 64'h1, '0, 1'b0, '0, 1'b0, 3'd0, "R4");
        p = fetch_pc; run_ctl(3'd1, 3'd4, 16'h0007, '0, 64'h0, '0, 1'b1, br_target(p, 16'h0007), 1'b0, 3'd0, "R3");
        p = fetch_pc; run_ctl(3'd1, 3'd2, 16'h0002, '0, 64'h8000_0000, '0, 1'b1, br_target(p, 16'h0002), 1'b0, 3'd0, "R3");
        p = fetch_pc; run_ctl(3'd1, 3'd6, 16'h0002, '0, 64'h0, 64'h0, 1'b0, '0, 1'b0, 3'd0, "R3");
    endtask

    task automatic t_likely();
        logic [63:0] p;
        p = fetch_pc; run_ctl(3'd2, 3'd0, 16'h0009, '0, 64'h7, 64'h7, 1'b1, br_target(p, 16'h0009), 1'b0, 3'd0, "R6");
        p = fetch_pc; run_ctl(3'd2, 3'd1, 16'h0009, '0, 64'h7, 64'h7, 1'b0, '0, 1'b1, 3'd0, "R6");
        p = fetch_pc; run_ctl(3'd2, 3'd5, 16'hFFF0, '0, 64'hFFFF_FFFF_FFFF_FFF0, '0, 1'b1, br_target(p, 16'hFFF0), 1'b0, 3'd0, "R6");
    endtask

    task automatic t_jumps();
        logic [63:0] p;
        p = fetch_pc; run_ctl(3'd4, 3'd0, '0, '0, 64'hFFFF_FFFF_8000_0FF8, '0, 1'b1, 64'hFFFF_FFFF_8000_0FF8, 1'b0, 3'd0, "R8");
        p = fetch_pc; run_ctl(3'd3, 3'd0, '0, 26'h0ABCDE, '0, '0, 1'b1, {p[63:28] + 36'd0, 26'h0ABCDE, 2'b00} & 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 3'd0, "R7");
        p = fetch_pc; run_ctl(3'd5, 3'd0, '0, 26'h3FFFFFF, '0, '0, 1'b1, {(p + 64'd4) >> 28, 26'h3FFFFFF, 2'b00}, 1'b0, 3'd0, "R7");
        p = fetch_pc; run_ctl(3'd6, 3'd0, '0, '0, 64'h0000_0000_0000_2000, '0, 1'b1, 64'h2000, 1'b0, 3'd0, "R9");
    endtask

    task automatic t_slot_ignored();
        logic [63:0] p;
        p = fetch_pc; run_ctl(3'd2, 3'd0, 16'h0020, '0, 64'h1, 64'h2, 1'b0, '0, 1'b1, 3'd5, "R10");
        p = fetch_pc; run_ctl(3'd1, 3'd1, 16'h0020, '0, 64'h1, 64'h2, 1'b1, br_target(p, 16'h0020), 1'b0, 3'd6, "R10");
        p = fetch_pc; run_ctl(3'd1, 3'd0, 16'h0020, '0, 64'h1, 64'h2, 1'b0, '0, 1'b0, 3'd1, "R10");
    endtask

    initial begin
        rst = 1'b1;
        idle_inputs();
        @(negedge clk);
        t_reset();
        t_sequential();
        t_branches();
        t_likely();
        t_jumps();
        t_slot_ignored();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule